// File: doc/BRIEF.md
# Clock controller register bank

This block holds the control words of a clock control unit behind a simple 32-bit word-addressed bus, and reports the frequency in Hz of whichever clock a select code names. Software writes and reads the 28 control words through one port. Hardware on the query side places a clock code on `clk_sel` and reads the frequency back from `freq_hz` in the same cycle.

The two PLL frequencies are not computed here. They arrive on `main_pll_hz` and `aux_pll_hz`. The block combines them with fields of the clock configuration word (word index 2): a bypass flag, a disable flag, a 3/4 source-scaling flag and two dividers. From these it forms the CPU, AHB and IPG frequencies.

The bus side runs a small response machine. Its states are RSP_IDLE (no access in the previous cycle), RSP_DATA (the previous access was accepted) and RSP_REJECT (the previous access fell outside the window or was misaligned). Every cycle it moves to RSP_IDLE when `bus_sel` is low. When `bus_sel` is high it moves to RSP_DATA if the address is word-aligned and inside the window, and to RSP_REJECT otherwise. `bus_err` is high exactly in RSP_REJECT.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset, words 0..9 read back 0x800B2C01, 0x84042800, 0xD0030000, 0x028A0100, 0x04008100, 0x00000438 and then 0x01010101 four times. Words 22..25 read 0x00A00000, 0x0000A030, 0x0000A030 and 0x43000000. All other words read 0.
- R2: A write with `bus_sel`=1 and `bus_we`=1 to an aligned byte address below 0x70 replaces all 32 bits of word `addr>>2`. A later read of that word returns the written value.
- R3: Read data appears on `bus_rdata` one clock after a read access (`bus_sel`=1, `bus_we`=0) is presented. `bus_rdata` is 0 after any cycle that is not an accepted read.
- R4: An access at byte address 0x70 or above returns 0 on `bus_rdata`, and `bus_err` is high for exactly the following cycle. A write there changes no word.
- R5: An access whose address bits 1:0 are not 00 is rejected the same way as in R4: the read returns 0, the write has no effect, and `bus_err` pulses.
- R6: `bus_err` is low in any cycle that does not follow a rejected access.
- R7: Main PLL frequency (select 1) is 24,000,000 when bit 22 of word 2 is set. Otherwise it is `main_pll_hz`.
- R8: Second PLL frequency (select 2) is 0 when bit 23 of word 2 is set. Otherwise it is `aux_pll_hz`.
- R9: CPU frequency (select 3) starts from the main PLL frequency. When bit 14 of word 2 is set, that value is first multiplied by 3 and divided by 4, without overflow. The result is then divided by 1 + bits 31:30 of word 2. All divisions truncate.
- R10: AHB frequency (select 4) is the CPU frequency divided by 1 + bits 29:28 of word 2. IPG frequency (select 5) is the AHB frequency divided by 2.
- R11: Select 0 returns 0, and select 6 returns 32,768. `sel_err` is low for select codes 0 to 6.
- R12: Select code 7 returns 0 with `sel_err` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle rejected-access flag |
| main_pll_hz | input | 32 | Main PLL output frequency in Hz |
| aux_pll_hz | input | 32 | Second PLL output frequency in Hz |
| clk_sel | input | 3 | Clock to report |
| freq_hz | output | 32 | Frequency of the selected clock |
| sel_err | output | 1 | Unsupported select code |

## Verification
The properties take `bus_sel`, `bus_we` and `bus_addr` to be stable over each clock edge. They also take the PLL inputs and `clk_sel` to be known whenever the frequency is checked. The stimulus drives every input only on the falling edge. Its random bus addresses mostly fall inside the window, with a fraction beyond 0x70 and a fraction misaligned. Random PLL frequencies cover the full 32-bit range, so the 3/4 scaling also runs near overflow.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int unsigned CFG_IDX      = 2;
    localparam int unsigned CPU_DIV_HI   = 31;
    localparam int unsigned CPU_DIV_LO   = 30;
    localparam int unsigned AHB_DIV_HI   = 29;
    localparam int unsigned AHB_DIV_LO   = 28;
    localparam int unsigned AUX_OFF_BIT  = 23;
    localparam int unsigned MAIN_BYP_BIT = 22;
    localparam int unsigned CPU_SRC_BIT  = 14;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_MAIN = 3'd1,
        SEL_AUX  = 3'd2,
        SEL_CPU  = 3'd3,
        SEL_AHB  = 3'd4,
        SEL_IPG  = 3'd5,
        SEL_SLOW = 3'd6,
        SEL_BAD  = 3'd7
    } clk_sel_e;

    typedef enum logic [1:0] {
        RSP_IDLE   = 2'd0,
        RSP_DATA   = 2'd1,
        RSP_REJECT = 2'd2
    } rsp_state_e;

    function automatic logic [31:0] word_reset_value(input int unsigned idx);
        logic [31:0] v;
        unique case (idx)
            0:             v = 32'h800B2C01;
            1:             v = 32'h84042800;
            2:             v = 32'hD0030000;
            3:             v = 32'h028A0100;
            4:             v = 32'h04008100;
            5:             v = 32'h00000438;
            6, 7, 8, 9:    v = 32'h01010101;
            22:            v = 32'h00A00000;
            23, 24:        v = 32'h0000A030;
            25:            v = 32'h43000000;
            default:       v = 32'h0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/clkctl_bus_fsm.sv
module clkctl_bus_fsm
    import clkctl_pkg::*;
#(
    parameter int unsigned NUM_REGS = 28,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              acc_ok,
    output logic              wr_en,
    output logic              rsp_err
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS * 4);

    rsp_state_e state_q, state_d;
    logic       addr_good;

    assign addr_good = (bus_addr < LIMIT) && (bus_addr[1:0] == 2'b00);
    assign acc_ok    = bus_sel && addr_good;
    assign wr_en     = acc_ok && bus_we;

    always_comb begin
        state_d = RSP_IDLE;
        unique case (state_q)
            RSP_IDLE, RSP_DATA, RSP_REJECT: begin
                if (!bus_sel)        state_d = RSP_IDLE;
                else if (addr_good)  state_d = RSP_DATA;
                else                 state_d = RSP_REJECT;
            end
            default:                 state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rsp_err = 1'b0;
        unique case (state_q)
            RSP_REJECT: rsp_err = 1'b1;
            default:    rsp_err = 1'b0;
        endcase
    end
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
    import clkctl_pkg::*;
#(
    parameter int unsigned NUM_REGS = 28,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_ok,
    input  logic              wr_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] cfg_word
);
    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    logic [DATA_W-1:0] words [NUM_REGS];
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rd_mux;

    assign idx = bus_addr[IDX_W+1:2];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= DATA_W'(word_reset_value(g));
            else if (wr_en && (idx == IDX_W'(g)))
                words[g] <= bus_wdata;
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) rd_mux = words[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (acc_ok && !bus_we) bus_rdata <= rd_mux;
        else                        bus_rdata <= '0;
    end

    assign cfg_word = words[CFG_IDX];
endmodule

// File: rtl/clkctl_freq_calc.sv
module clkctl_freq_calc
    import clkctl_pkg::*;
#(
    parameter int unsigned REF_HZ  = 24000000,
    parameter int unsigned SLOW_HZ = 32768
) (
    input  logic [31:0] cfg_word,
    input  logic [31:0] main_pll_hz,
    input  logic [31:0] aux_pll_hz,
    input  logic [2:0]  clk_sel,
    output logic [31:0] freq_hz,
    output logic        sel_err
);
    localparam int unsigned WIDE_W = 34;

    logic [31:0]       main_f, aux_f, src_f, cpu_f, ahb_f, ipg_f;
    logic [WIDE_W-1:0] scaled;
    clk_sel_e          sel;

    function automatic logic [31:0] div_small(input logic [31:0] x, input logic [1:0] d);
        logic [31:0] r;
        unique case (d)
            2'd0: r = x;
            2'd1: r = x >> 1;
            2'd2: r = x / 32'd3;
            2'd3: r = x >> 2;
            default: r = x;
        endcase
        return r;
    endfunction

    assign main_f = cfg_word[MAIN_BYP_BIT] ? 32'(REF_HZ) : main_pll_hz;
    assign aux_f  = cfg_word[AUX_OFF_BIT] ? 32'd0 : aux_pll_hz;
    assign scaled = {2'b00, main_f} * WIDE_W'(3);
    assign src_f  = cfg_word[CPU_SRC_BIT] ? scaled[WIDE_W-1:2] : main_f;
    assign cpu_f  = div_small(src_f, cfg_word[CPU_DIV_HI:CPU_DIV_LO]);
    assign ahb_f  = div_small(cpu_f, cfg_word[AHB_DIV_HI:AHB_DIV_LO]);
    assign ipg_f  = ahb_f >> 1;
    assign sel    = clk_sel_e'(clk_sel);

    always_comb begin
        freq_hz = '0;
        sel_err = 1'b0;
        unique case (sel)
            SEL_NONE: freq_hz = '0;
            SEL_MAIN: freq_hz = main_f;
            SEL_AUX:  freq_hz = aux_f;
            SEL_CPU:  freq_hz = cpu_f;
            SEL_AHB:  freq_hz = ahb_f;
            SEL_IPG:  freq_hz = ipg_f;
            SEL_SLOW: freq_hz = 32'(SLOW_HZ);
            SEL_BAD:  sel_err = 1'b1;
            default:  sel_err = 1'b1;
        endcase
    end
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int unsigned NUM_REGS = 28,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned REF_HZ   = 24000000,
    parameter int unsigned SLOW_HZ  = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic [31:0]       main_pll_hz,
    input  logic [31:0]       aux_pll_hz,
    input  logic [2:0]        clk_sel,
    output logic [31:0]       freq_hz,
    output logic              sel_err
);
    logic        acc_ok, wr_en;
    logic [31:0] cfg_word;

    clkctl_bus_fsm #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .acc_ok(acc_ok), .wr_en(wr_en), .rsp_err(bus_err)
    );

    clkctl_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(32)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_ok(acc_ok), .wr_en(wr_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_word(cfg_word)
    );

    clkctl_freq_calc #(.REF_HZ(REF_HZ), .SLOW_HZ(SLOW_HZ)) u_freq (
        .cfg_word(cfg_word), .main_pll_hz(main_pll_hz), .aux_pll_hz(aux_pll_hz),
        .clk_sel(clk_sel), .freq_hz(freq_hz), .sel_err(sel_err)
    );
endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
    parameter int unsigned NUM_REGS = 28,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned REF_HZ   = 24000000,
    parameter int unsigned SLOW_HZ  = 32768
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic [31:0]       cfg_word,
    input logic [2:0]        clk_sel,
    input logic [31:0]       freq_hz,
    input logic              sel_err
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS * 4);

    // R4
    window_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr >= LIMIT) |=> (bus_err && bus_rdata == 32'd0));

    // R5
    misalign_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr[1:0] != 2'b00) |=> (bus_err && bus_rdata == 32'd0));

    // R6
    err_only_after_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel || (bus_addr < LIMIT && bus_addr[1:0] == 2'b00)) |=> !bus_err);

    // R3
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel || bus_we) |=> (bus_rdata == 32'd0));

    // R7
    main_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd1 && cfg_word[22]) |-> (freq_hz == 32'(REF_HZ)));

    // R8
    aux_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd2 && cfg_word[23]) |-> (freq_hz == 32'd0));

    // R11
    slow_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd6) |-> (freq_hz == 32'(SLOW_HZ) && !sel_err));

    // R11
    none_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0) |-> (freq_hz == 32'd0 && !sel_err));

    // R12
    bad_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd7) |-> (freq_hz == 32'd0 && sel_err));
endmodule

bind clkctl_regbank clkctl_regbank_chk #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .REF_HZ(REF_HZ), .SLOW_HZ(SLOW_HZ)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .cfg_word(cfg_word), .clk_sel(clk_sel), .freq_hz(freq_hz), .sel_err(sel_err)
);

// File: tb/clkctl_regbank_tb_top.sv
`timescale 1ns/1ps
module clkctl_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] main_pll_hz = 32'd0, aux_pll_hz = 32'd0;
    logic [2:0]  clk_sel = 3'd0;
    logic [31:0] freq_hz;
    logic        sel_err;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] mirror [28];

    always #4 clk = ~clk;

    clkctl_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .main_pll_hz(main_pll_hz), .aux_pll_hz(aux_pll_hz),
        .clk_sel(clk_sel), .freq_hz(freq_hz), .sel_err(sel_err)
    );

    function automatic logic [31:0] exp_reset(int i);
        if (i == 0) return 32'h800B2C01;
        if (i == 1) return 32'h84042800;
        if (i == 2) return 32'hD0030000;
        if (i == 3) return 32'h028A0100;
        if (i == 4) return 32'h04008100;
        if (i == 5) return 32'h00000438;
        if (i >= 6 && i <= 9) return 32'h01010101;
        if (i == 22) return 32'h00A00000;
        if (i == 23 || i == 24) return 32'h0000A030;
        if (i == 25) return 32'h43000000;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_freq(int s, logic [31:0] cfg, logic [31:0] m, logic [31:0] a);
        longint unsigned mf, cpu, ahb;
        mf  = cfg[22] ? 64'd24000000 : {32'd0, m};
        cpu = cfg[14] ? (mf * 3) / 4 : mf;
        cpu = cpu / (1 + cfg[31:30]);
        ahb = cpu / (1 + cfg[29:28]);
        case (s)
            1: return mf[31:0];
            2: return cfg[23] ? 32'd0 : a;
            3: return cpu[31:0];
            4: return ahb[31:0];
            5: return ahb[31:0] / 2;
            6: return 32'd32768;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic access(logic we, logic [11:0] a, logic [31:0] d,
                          output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        rd = bus_rdata; er = bus_err;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic check_freqs(string req);
        for (int s = 0; s < 8; s++) begin
            clk_sel = 3'(s);
            #1;
            chk(req, freq_hz, exp_freq(s, mirror[2], main_pll_hz, aux_pll_hz));
            chk("R11/R12 sel_err", {31'd0, sel_err}, (s == 7) ? 32'd1 : 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        int unsigned r;
        r = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int i = 0; i < 28; i++) begin
            mirror[i] = exp_reset(i);
            access(1'b0, 12'(i * 4), 32'd0, rd, er);
            chk("R1 reset word", rd, exp_reset(i));
            chk("R6 no err in window", {31'd0, er}, 32'd0);
        end
        // R3 rdata clears after idle cycle
        @(negedge clk);
        chk("R3 idle rdata", bus_rdata, 32'd0);

        // R2 write/read, boundary word 27
        access(1'b1, 12'h6C, 32'hA5A5_5A5A, rd, er);
        mirror[27] = 32'hA5A5_5A5A;
        chk("R3 rdata after write", rd, 32'd0);
        access(1'b0, 12'h6C, 32'd0, rd, er);
        chk("R2 last word", rd, 32'hA5A5_5A5A);

        // R4 out of window at 0x70 and 0xFFC
        access(1'b1, 12'h70, 32'hDEAD_BEEF, rd, er);
        chk("R4 write err", {31'd0, er}, 32'd1);
        @(negedge clk);
        chk("R4 err one cycle", {31'd0, bus_err}, 32'd0);
        access(1'b0, 12'hFFC, 32'd0, rd, er);
        chk("R4 read zero", rd, 32'd0);
        chk("R4 read err", {31'd0, er}, 32'd1);

        // R5 misaligned write to word 3 is ignored
        access(1'b1, 12'h0E, 32'h1234_5678, rd, er);
        chk("R5 misaligned err", {31'd0, er}, 32'd1);
        access(1'b0, 12'h0D, 32'd0, rd, er);
        chk("R5 misaligned read zero", rd, 32'd0);
        access(1'b0, 12'h0C, 32'd0, rd, er);
        chk("R5 word untouched", rd, mirror[3]);

        // Random bus traffic (R2 R4 R5 R6)
        for (int k = 0; k < 300; k++) begin
            logic [11:0] a;
            logic        w;
            logic [31:0] d;
            logic        good;
            r = $urandom;
            a = (r[3:0] == 0) ? 12'($urandom) : 12'((r[31:8] % 30) * 4);
            w = r[4];
            d = $urandom;
            if (a == 12'h08 && w) d[22] = 1'b0;
            good = (a < 12'h70) && (a[1:0] == 2'b00);
            access(w, a, d, rd, er);
            chk("R4/R5/R6 err flag", {31'd0, er}, good ? 32'd0 : 32'd1);
            if (good && w) mirror[a[6:2]] = d;
            if (!w) chk("R2 random read", rd, good ? mirror[a[6:2]] : 32'd0);
        end

        // Frequency checks: reset-like config (R9 R10)
        main_pll_hz = 32'd532000000; aux_pll_hz = 32'd240000000;
        access(1'b1, 12'h08, 32'hD0030000, rd, er);
        mirror[2] = 32'hD0030000;
        check_freqs("R9/R10 default config");

        // R7 bypass
        access(1'b1, 12'h08, 32'h0040_0000, rd, er);
        mirror[2] = 32'h0040_0000;
        check_freqs("R7 bypass");
        // R8 aux disable
        access(1'b1, 12'h08, 32'h0080_0000, rd, er);
        mirror[2] = 32'h0080_0000;
        check_freqs("R8 aux off");
        // R9 scaling at full range
        main_pll_hz = 32'hFFFF_FFFF;
        access(1'b1, 12'h08, 32'h0000_4000, rd, er);
        mirror[2] = 32'h0000_4000;
        clk_sel = 3'd3; #1;
        chk("R9 scale no overflow", freq_hz, 32'hBFFF_FFFF);
        check_freqs("R9 scale");

        // Random configurations (R7..R12)
        for (int k = 0; k < 60; k++) begin
            logic [31:0] c;
            c = $urandom;
            main_pll_hz = $urandom; aux_pll_hz = $urandom;
            access(1'b1, 12'h08, c, rd, er);
            mirror[2] = c;
            check_freqs("R7-R12 random cfg");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule